// File: doc/BRIEF.md
# Handshake Link Protocol Monitor

This block watches one valid/ready stream link without driving any of it. It takes the link's valid, ready and data wires as inputs only, so it cannot change how the link behaves and cannot close a combinational loop through it. On every clock it sorts the link cycle into one of four classes and pulses a flag when a word is accepted. It also keeps a saturating count of accepted words.

The monitor also polices the producer side of the contract. An offer that is waiting (valid high, ready low) must keep its payload and must not be withdrawn before it is accepted. A break of either rule sets its own sticky error bit. A progress watchdog sets a third sticky bit when a programmable number of consecutive cycles pass with no accepted word. A one-cycle clear input drops all sticky bits and restarts the watchdog. Every output is registered, so each output describes the link cycle that ended at the previous rising edge.

Top module: `hs_link_monitor`

## Requirements
- R1: `xfer_pulse` is high in the cycle after a cycle where `link_valid` and `link_ready` were both high. It is low after every other cycle.
- R2: In the cycle after each non-reset cycle, exactly one class output is high. The class is picked by {valid, ready}: 00 selects `cls_idle`, 01 selects `cls_bubble`, 10 selects `cls_stall` and 11 selects `cls_xfer`.
- R3: The sticky `err_data_chg` flag is set when a stall cycle is followed by a cycle where valid is still high and `link_data` differs from the value it had in the stall cycle.
- R4: The sticky `err_valid_drop` flag is set when a stall cycle is followed by a cycle where valid is low.
- R5: A stall of any length with unchanged data sets no flag. A data change after many stall cycles is still caught.
- R6: Each transfer increments `xfer_count` once, including transfers on consecutive cycles. Bubble cycles (ready high, valid low) never count.
- R7: `xfer_count` stops at 2^CNT_W-1 and does not wrap.
- R8: `err_no_progress` is set once PROGRESS_LIMIT consecutive cycles pass with no transfer. A transfer restarts the count, so a gap of PROGRESS_LIMIT-1 cycles leaves the flag low.
- R9: A high `clr_flags` at a clock edge clears the three sticky flags and restarts the progress count. A violation detected in that same cycle still sets its flag.
- R10: Reset sets every output to zero. A stall during reset does not arm the stability checks for the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| link_valid | input | 1 | Observed producer valid |
| link_ready | input | 1 | Observed consumer ready |
| link_data | input | DATA_W | Observed payload |
| clr_flags | input | 1 | One-cycle clear of the sticky flags and the progress count |
| cls_idle | output | 1 | Previous cycle was idle |
| cls_bubble | output | 1 | Previous cycle was a bubble |
| cls_stall | output | 1 | Previous cycle was a stall |
| cls_xfer | output | 1 | Previous cycle was a transfer |
| xfer_pulse | output | 1 | One pulse per accepted word |
| xfer_count | output | CNT_W | Saturating count of accepted words |
| err_data_chg | output | 1 | Sticky: payload changed while an offer was waiting |
| err_valid_drop | output | 1 | Sticky: valid withdrawn while an offer was waiting |
| err_no_progress | output | 1 | Sticky: no transfer within PROGRESS_LIMIT cycles |

## Verification
The assertions assume that link inputs settle well before each rising edge. They also assume that reset is high at the first edge, so the one-cycle history they use never points back to an unknown pre-reset value. The stimulus changes valid, ready, data and clear only on the falling edge and holds reset through the first two edges. Protocol breaks are injected on purpose, each in a single cycle right after a stall. Each break is followed by a clear pulse, so the effects of one deliberate violation stay separate from the next.

// File: rtl/hsmon_pkg.sv
package hsmon_pkg;
  // Class code equals {valid, ready}
  typedef enum logic [1:0] {
    CLS_IDLE   = 2'b00,
    CLS_BUBBLE = 2'b01,
    CLS_STALL  = 2'b10,
    CLS_XFER   = 2'b11
  } link_cls_e;

  function automatic link_cls_e cls_of(input logic v, input logic r);
    return link_cls_e'({v, r});
  endfunction
endpackage

// File: rtl/hsmon_classify.sv
module hsmon_classify
  import hsmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             rdy,
  output logic             cls_idle,
  output logic             cls_bubble,
  output logic             cls_stall,
  output logic             cls_xfer,
  output logic             xfer_pulse,
  output logic [CNT_W-1:0] xfer_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  link_cls_e cur_cls;
  assign cur_cls = cls_of(vld, rdy);

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_idle   <= 1'b0;
      cls_bubble <= 1'b0;
      cls_stall  <= 1'b0;
      cls_xfer   <= 1'b0;
      xfer_pulse <= 1'b0;
      xfer_count <= '0;
    end else begin
      cls_idle   <= (cur_cls == CLS_IDLE);
      cls_bubble <= (cur_cls == CLS_BUBBLE);
      cls_stall  <= (cur_cls == CLS_STALL);
      cls_xfer   <= (cur_cls == CLS_XFER);
      xfer_pulse <= (cur_cls == CLS_XFER);
      if (cur_cls == CLS_XFER && xfer_count != CNT_MAX)
        xfer_count <= xfer_count + 1'b1;
    end
  end

  // R1
  xfer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && rdy) |=> xfer_pulse);
  // R1
  no_false_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(vld && rdy) |=> !xfer_pulse);
  // R2
  stall_class_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !rdy) |=> (cls_stall && !cls_xfer && !cls_idle && !cls_bubble));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && rdy && xfer_count != CNT_MAX) |=> (xfer_count == $past(xfer_count) + 1'b1));
  // R6
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld && rdy) |=> $stable(xfer_count));
  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_count == CNT_MAX) |=> (xfer_count == CNT_MAX));
endmodule

// File: rtl/hsmon_stability.sv
module hsmon_stability #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              rdy,
  input  logic [DATA_W-1:0] data,
  input  logic              clr,
  output logic              err_data_chg,
  output logic              err_valid_drop
);
  logic              held_stall;
  logic [DATA_W-1:0] held_data;
  logic              hit_data;
  logic              hit_drop;

  assign hit_data = held_stall && vld && (data != held_data);
  assign hit_drop = held_stall && !vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_stall     <= 1'b0;
      held_data      <= '0;
      err_data_chg   <= 1'b0;
      err_valid_drop <= 1'b0;
    end else begin
      held_stall     <= vld && !rdy;
      held_data      <= data;
      err_data_chg   <= (err_data_chg && !clr) || hit_data;
      err_valid_drop <= (err_valid_drop && !clr) || hit_drop;
    end
  end

  // R3
  data_chg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld && !rdy) && vld && data != $past(data)) |=> err_data_chg);
  // R4
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld && !rdy) && !vld) |=> err_valid_drop);
  // R9
  data_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_data_chg && !clr) |=> err_data_chg);
  // R9
  drop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid_drop && !clr) |=> err_valid_drop);
  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!err_data_chg && !err_valid_drop));
endmodule

// File: rtl/hsmon_watchdog.sv
module hsmon_watchdog #(
  parameter int PROGRESS_LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic rdy,
  input  logic clr,
  output logic err_no_progress
);
  localparam int GAP_W = $clog2(PROGRESS_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_TOP  = GAP_W'(PROGRESS_LIMIT);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(PROGRESS_LIMIT - 1);

  logic [GAP_W-1:0] gap_q;
  logic             moved;
  logic             expire;

  assign moved  = vld && rdy;
  assign expire = !moved && !clr && (gap_q == GAP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q           <= '0;
      err_no_progress <= 1'b0;
    end else begin
      if (moved || clr)
        gap_q <= '0;
      else if (gap_q != GAP_TOP)
        gap_q <= gap_q + 1'b1;
      err_no_progress <= (err_no_progress && !clr) || expire;
    end
  end

  // R8
  progress_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (moved && !err_no_progress) |=> !err_no_progress);
  // R9
  wd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_no_progress && !clr) |=> err_no_progress);
  // R10
  wd_reset_chk: assert property (@(posedge clk)
    rst |=> !err_no_progress);
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor #(
  parameter int DATA_W         = 32,
  parameter int CNT_W          = 16,
  parameter int PROGRESS_LIMIT = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_valid,
  input  logic              link_ready,
  input  logic [DATA_W-1:0] link_data,
  input  logic              clr_flags,
  output logic              cls_idle,
  output logic              cls_bubble,
  output logic              cls_stall,
  output logic              cls_xfer,
  output logic              xfer_pulse,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              err_data_chg,
  output logic              err_valid_drop,
  output logic              err_no_progress
);
  hsmon_classify #(.CNT_W(CNT_W)) u_cls (
    .clk        (clk),
    .rst        (rst),
    .vld        (link_valid),
    .rdy        (link_ready),
    .cls_idle   (cls_idle),
    .cls_bubble (cls_bubble),
    .cls_stall  (cls_stall),
    .cls_xfer   (cls_xfer),
    .xfer_pulse (xfer_pulse),
    .xfer_count (xfer_count)
  );

  hsmon_stability #(.DATA_W(DATA_W)) u_stab (
    .clk            (clk),
    .rst            (rst),
    .vld            (link_valid),
    .rdy            (link_ready),
    .data           (link_data),
    .clr            (clr_flags),
    .err_data_chg   (err_data_chg),
    .err_valid_drop (err_valid_drop)
  );

  hsmon_watchdog #(.PROGRESS_LIMIT(PROGRESS_LIMIT)) u_wd (
    .clk             (clk),
    .rst             (rst),
    .vld             (link_valid),
    .rdy             (link_ready),
    .clr             (clr_flags),
    .err_no_progress (err_no_progress)
  );

  // R2
  one_class_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones({cls_idle, cls_bubble, cls_stall, cls_xfer}) == 1));
endmodule

// File: tb/sim_hs_link_monitor.sv
`timescale 1ns/1ps
module sim_hs_link_monitor;
  localparam int DW    = 16;
  localparam int CW    = 5;
  localparam int LIM   = 20;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          vld, rdy, clr;
  logic [DW-1:0] dat;
  logic          c_idle, c_bub, c_stall, c_xfer, pulse;
  logic [CW-1:0] cnt;
  logic          e_dc, e_vd, e_wd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int            m_cls;
  bit            m_pulse;
  int            m_cnt;
  bit            m_dc, m_vd, m_wd;
  int            m_gap;
  bit            m_pstall;
  logic [DW-1:0] m_pdat;

  hs_link_monitor #(.DATA_W(DW), .CNT_W(CW), .PROGRESS_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .link_valid(vld), .link_ready(rdy), .link_data(dat),
    .clr_flags(clr), .cls_idle(c_idle), .cls_bubble(c_bub), .cls_stall(c_stall),
    .cls_xfer(c_xfer), .xfer_pulse(pulse), .xfer_count(cnt),
    .err_data_chg(e_dc), .err_valid_drop(e_vd), .err_no_progress(e_wd)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit st, xf, hd, hv;
    if (rst) begin
      m_cls = -1; m_pulse = 0; m_cnt = 0; m_dc = 0; m_vd = 0; m_wd = 0;
      m_gap = 0; m_pstall = 0; m_pdat = '0;
    end else begin
      st = vld && !rdy;
      xf = vld && rdy;
      hd = m_pstall && vld && (dat != m_pdat);
      hv = m_pstall && !vld;
      m_dc = (m_dc && !clr) || hd;
      m_vd = (m_vd && !clr) || hv;
      if (xf || clr) m_gap = 0; else m_gap++;
      m_wd = (m_wd && !clr) || (m_gap >= LIM);
      m_cls = {vld, rdy};
      m_pulse = xf;
      if (xf && m_cnt < CMAX) m_cnt++;
      m_pstall = st;
      m_pdat = dat;
    end
  endtask

  task automatic compare_all();
    int exp_cls;
    exp_cls = (m_cls < 0) ? 0 : (1 << m_cls);
    chk("R2 class", {c_xfer, c_stall, c_bub, c_idle}, exp_cls);
    chk("R1 pulse", pulse, m_pulse);
    chk("R6 count", cnt, m_cnt);
    chk("R3 data flag", e_dc, m_dc);
    chk("R4 drop flag", e_vd, m_vd);
    chk("R8 progress flag", e_wd, m_wd);
  endtask

  // drive at negedge, model at posedge, compare at the following negedge
  task automatic step(input logic v, input logic r, input logic [DW-1:0] d, input logic c);
    vld = v; rdy = r; dat = d; clr = c;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual 0 expected 1 completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    // R10: stall held through reset must not arm the checks
    step(1'b1, 1'b0, 16'h0011, 1'b0);
    step(1'b1, 1'b0, 16'h0011, 1'b0);
    chk("R10 reset class", {c_xfer, c_stall, c_bub, c_idle}, 0);
    chk("R10 reset count", cnt, 0);
    chk("R10 reset flags", {e_dc, e_vd, e_wd}, 0);
    rst = 1'b0;
    step(1'b1, 1'b0, 16'h0022, 1'b0);
    chk("R10 no check after reset", {e_dc, e_vd}, 0);
    step(1'b1, 1'b1, 16'h0022, 1'b0);
    chk("R1 transfer pulse", pulse, 1);

    // R2 / R6: each class, bubble not counted, back-to-back counted
    step(1'b0, 1'b0, 16'h0000, 1'b0);
    chk("R2 idle", c_idle, 1);
    step(1'b0, 1'b1, 16'h0033, 1'b0);
    chk("R6 bubble not counted", cnt, 1);
    chk("R1 bubble no pulse", pulse, 0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, DW'(16'h0100 + i), 1'b0);
    chk("R6 back-to-back", cnt, 5);

    // R5: long stall with stable data, then accept
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 16'h0A5A, 1'b0);
    step(1'b1, 1'b1, 16'h0A5A, 1'b0);
    chk("R5 long stall clean", {e_dc, e_vd}, 0);

    // R3 + R5: data change after a long stall
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 16'h0B0B, 1'b0);
    step(1'b1, 1'b0, 16'h0B0C, 1'b0);
    chk("R3 data change flagged", e_dc, 1);
    step(1'b1, 1'b1, 16'h0B0C, 1'b0);
    chk("R3 flag sticky", e_dc, 1);
    step(1'b0, 1'b0, 16'h0000, 1'b1);
    chk("R9 clear", e_dc, 0);

    // R4: valid withdrawn while waiting
    step(1'b1, 1'b0, 16'h0C0C, 1'b0);
    step(1'b0, 1'b0, 16'h0C0C, 1'b0);
    chk("R4 drop flagged", e_vd, 1);
    // R9: a new violation in the clear cycle still sets its flag
    step(1'b1, 1'b0, 16'h0D0D, 1'b0);
    step(1'b1, 1'b0, 16'h0D0E, 1'b1);
    chk("R9 clear drops old flag", e_vd, 0);
    chk("R9 same-cycle detect wins", e_dc, 1);
    step(1'b1, 1'b1, 16'h0D0E, 1'b1);
    chk("R9 clear all", {e_dc, e_vd, e_wd}, 0);

    // R8: gap of LIM-1 is fine, gap of LIM trips
    for (int i = 0; i < LIM - 1; i++) step(1'b0, 1'b0, 16'h0000, 1'b0);
    chk("R8 short gap", e_wd, 0);
    step(1'b1, 1'b1, 16'h0E0E, 1'b0);
    for (int i = 0; i < LIM - 1; i++) step(1'b0, 1'b1, 16'h0000, 1'b0);
    chk("R8 restart on transfer", e_wd, 0);
    step(1'b0, 1'b1, 16'h0000, 1'b0);
    chk("R8 gap expired", e_wd, 1);
    step(1'b1, 1'b1, 16'h0E0F, 1'b0);
    chk("R8 sticky after transfer", e_wd, 1);
    step(1'b0, 1'b0, 16'h0000, 1'b1);
    chk("R9 progress clear", e_wd, 0);

    // R7: saturation
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, DW'(i), 1'b0);
    chk("R7 saturated", cnt, CMAX);
    step(1'b1, 1'b1, 16'h7777, 1'b0);
    chk("R7 no wrap", cnt, CMAX);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule